// File: doc/BRIEF.md
# Receive Error Discard and Acknowledge Engine

This block sits on the receive side of a cluster network adapter. It takes one incoming packet at a time. Each packet carries a source node id, the page attributes that apply at the destination, an error flag, a target address and a data word. A packet that arrives intact on a path in normal state is written to local memory if its page accepts writes. If it also asks for an acknowledge, the block queues an acknowledge packet addressed back to the sender.

An errored packet puts its source path into an error state that holds until software clears it. Every later packet on that path is then dropped. This keeps the packet order on every path intact. It also means an acknowledge returned to a sender proves that all earlier packets on that path arrived. A page flagged to accept writes under error still takes data while its path is in error, but no acknowledge is ever generated on such a path. Writes to pages flagged for interrupts raise a one-cycle interrupt pulse once memory has taken the write.

Both outputs use valid/ready handshakes. A full acknowledge queue or a pending memory write stalls the input.

Top module: `rx_discard_ack_engine`

## Requirements
- R1: After reset, in_ready is 1 and mem_valid, ack_valid and irq are 0.
- R2: A packet accepted with in_err 0, on a path in normal state, with pg_rx_en 1, produces exactly one memory write carrying its in_addr and in_data. mem_valid rises in the cycle after acceptance.
- R3: A packet with pg_rx_en 0 produces no memory write.
- R4: A packet accepted with in_err 1 is neither written nor acknowledged, and it puts the path of its in_src into error state.
- R5: While a path is in error state, its packets are dropped unless pg_rx_err_ok is 1. Paths of other sources are unaffected.
- R6: A packet with in_err 0 and req_ack 1 on a path in normal state queues one acknowledge whose ack_dst equals its in_src. This happens whatever pg_rx_en is.
- R7: A packet with req_ack 1 on a path in error state produces no acknowledge, even when its page accepts writes under error.
- R8: A packet with pg_rx_en 1 and pg_rx_err_ok 1 is written even while its path is in error state.
- R9: A cycle with clr_valid 1 returns the path clr_src to normal state for packets accepted in later cycles. Other paths are not changed.
- R10: If an errored packet and a clear for the same source occur in the same cycle, the path ends in error state.
- R11: irq is high for exactly one cycle, the cycle after a memory write handshake, and only for a packet accepted with pg_irq 1.
- R12: The acknowledge queue holds two entries. While it holds two, in_ready is 0. ack_dst stays stable while ack_valid is 1 and ack_ready is 0.
- R13: While a write is pending with mem_ready 0, in_ready is 0 and mem_addr and mem_data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Packet is accepted this cycle if in_valid |
| in_src | input | SRC_W | Source node id (path index) |
| in_err | input | 1 | Packet failed its integrity check |
| req_ack | input | 1 | Packet requests an acknowledge |
| pg_rx_en | input | 1 | Page accepts received writes |
| pg_rx_err_ok | input | 1 | Page accepts writes while path is in error |
| pg_irq | input | 1 | Interrupt after write to this page |
| in_addr | input | ADDR_W | Local write address |
| in_data | input | DATA_W | Write data |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| ack_valid | output | 1 | Acknowledge packet pending |
| ack_ready | input | 1 | Network takes the acknowledge |
| ack_dst | output | SRC_W | Node to which the acknowledge is sent |
| irq | output | 1 | Receive interrupt pulse |
| clr_valid | input | 1 | Software error clear strobe |
| clr_src | input | SRC_W | Path to clear |

## Verification
The bench drives an errored packet and then good packets on the same path, and good packets on a second path. A design that forgot the sticky state would write or acknowledge the follow-up traffic, and a design that set the wrong bit would stall the healthy path. It sends an acknowledge request on an errored path whose page accepts writes under error, which catches a design that ties acknowledge generation to the write. It also collides an error with a clear for the same source, where letting the clear win would reopen a path that just failed. Finally it holds back both output handshakes: a design that ignored the full queue or the pending write would lose or overwrite an acknowledge or a write.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    // Outcome of one accepted packet
    typedef struct packed {
        logic store;     // write to local memory
        logic ack;       // queue an acknowledge to the sender
        logic mark_err;  // move the source path to error state
    } rxe_verdict_t;

endpackage

// File: rtl/rxe_path_state.sv
module rxe_path_state #(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] rd_src,
    output logic             rd_err,
    input  logic             set_valid,
    input  logic [SRC_W-1:0] set_src,
    input  logic             clr_valid,
    input  logic [SRC_W-1:0] clr_src
);
    localparam int NODES = 1 << SRC_W;

    typedef struct packed {
        logic [NODES-1:0] err;
    } state_t;

    state_t st_d, st_q;

    // Set has priority over clear: the newer failure must stay visible.
    for (genvar i = 0; i < NODES; i++) begin : g_path
        always_comb begin
            st_d.err[i] = (set_valid && set_src == SRC_W'(i)) ||
                          (st_q.err[i] && !(clr_valid && clr_src == SRC_W'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_err = st_q.err[rd_src];

    // R4 R9: an error bit never drops unless a clear was issued
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_valid) |-> ((st_q.err & $past(st_q.err)) == $past(st_q.err)));

endmodule

// File: rtl/rxe_classify.sv
module rxe_classify
    import rxe_pkg::*;
(
    input  logic         fire,
    input  logic         pkt_err,
    input  logic         path_err,
    input  logic         rx_en,
    input  logic         rx_err_ok,
    input  logic         want_ack,
    output rxe_verdict_t verdict
);
    always_comb begin
        verdict          = '0;
        verdict.mark_err = fire && pkt_err;
        verdict.store    = fire && !pkt_err && rx_en && (!path_err || rx_err_ok);
        verdict.ack      = fire && !pkt_err && !path_err && want_ack;
    end
endmodule

// File: rtl/rxe_ack_fifo.sv
module rxe_ack_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         pop_valid,
    input  logic         pop_ready,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } state_t;

    state_t st_d, st_q;
    logic   pop;

    assign pop       = pop_valid && pop_ready;
    assign pop_valid = st_q.cnt != '0;
    assign full      = st_q.cnt == CNT_W'(DEPTH);
    assign head      = st_q.mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R12
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready) |=> (pop_valid && $stable(head)));

endmodule

// File: rtl/rxe_write_stage.sv
module rxe_write_stage #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_irq,
    output logic              free,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              irq
);
    typedef struct packed {
        logic              valid;
        logic              irq_en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              irq;
    } state_t;

    state_t st_d, st_q;
    logic   done;

    assign done = st_q.valid && mem_ready;
    assign free = !st_q.valid || mem_ready;

    always_comb begin
        st_d     = st_q;
        st_d.irq = done && st_q.irq_en;
        if (load) begin
            st_d.valid  = 1'b1;
            st_d.irq_en = load_irq;
            st_d.addr   = load_addr;
            st_d.data   = load_data;
        end else if (done) begin
            st_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_valid = st_q.valid;
    assign mem_addr  = st_q.addr;
    assign mem_data  = st_q.data;
    assign irq       = st_q.irq;

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R11
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_valid && mem_ready));

endmodule

// File: rtl/rx_discard_ack_engine.sv
module rx_discard_ack_engine
    import rxe_pkg::*;
#(
    parameter int SRC_W     = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ACK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SRC_W-1:0]  in_src,
    input  logic              in_err,
    input  logic              req_ack,
    input  logic              pg_rx_en,
    input  logic              pg_rx_err_ok,
    input  logic              pg_irq,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic [SRC_W-1:0]  ack_dst,
    output logic              irq,
    input  logic              clr_valid,
    input  logic [SRC_W-1:0]  clr_src
);
    rxe_verdict_t verdict;
    logic         fire;
    logic         path_err;
    logic         ack_full;
    logic         stage_free;

    assign in_ready = !ack_full && stage_free;
    assign fire     = in_valid && in_ready;

    rxe_path_state #(.SRC_W(SRC_W)) u_paths (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_src    (in_src),
        .rd_err    (path_err),
        .set_valid (verdict.mark_err),
        .set_src   (in_src),
        .clr_valid (clr_valid),
        .clr_src   (clr_src)
    );

    rxe_classify u_classify (
        .fire      (fire),
        .pkt_err   (in_err),
        .path_err  (path_err),
        .rx_en     (pg_rx_en),
        .rx_err_ok (pg_rx_err_ok),
        .want_ack  (req_ack),
        .verdict   (verdict)
    );

    rxe_write_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_write (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (verdict.store),
        .load_addr (in_addr),
        .load_data (in_data),
        .load_irq  (pg_irq),
        .free      (stage_free),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .irq       (irq)
    );

    rxe_ack_fifo #(.DEPTH(ACK_DEPTH), .W(SRC_W)) u_ackq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (verdict.ack),
        .push_data (in_src),
        .full      (ack_full),
        .pop_valid (ack_valid),
        .pop_ready (ack_ready),
        .head      (ack_dst)
    );

    // R7: a path in error never yields an acknowledge
    errored_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && path_err) |-> !verdict.ack);

    // R4: an errored packet is never stored
    bad_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_err) |=> !(mem_valid && $changed(mem_addr) && !$past(mem_valid)));

endmodule

// File: tb/rx_discard_ack_engine_bench.sv
module rx_discard_ack_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_W  = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [SRC_W-1:0] in_src = '0;
    logic in_err = 1'b0, req_ack = 1'b0, pg_rx_en = 1'b0, pg_rx_err_ok = 1'b0, pg_irq = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic mem_valid, mem_ready = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic ack_valid, ack_ready = 1'b1;
    logic [SRC_W-1:0] ack_dst;
    logic irq;
    logic clr_valid = 1'b0;
    logic [SRC_W-1:0] clr_src = '0;

    int n_cmp = 0, n_bad = 0;
    int wr_cnt = 0, ack_cnt = 0, irq_cnt = 0;
    int last_addr = 0, last_data = 0, last_dst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_discard_ack_engine #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx_discard_ack_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_err(in_err), .req_ack(req_ack), .pg_rx_en(pg_rx_en),
        .pg_rx_err_ok(pg_rx_err_ok), .pg_irq(pg_irq), .in_addr(in_addr), .in_data(in_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_dst(ack_dst), .irq(irq),
        .clr_valid(clr_valid), .clr_src(clr_src)
    );

    // Output monitor, sampling a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                wr_cnt++; last_addr = int'(mem_addr); last_data = int'(mem_data);
            end
            if (ack_valid && ack_ready) begin
                ack_cnt++; last_dst = int'(ack_dst);
            end
            if (irq) irq_cnt++;
        end
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(int src, int addr, int data, bit rx, bit irqf, bit errok, bit ack, bit bad);
        @(negedge clk);
        in_valid = 1'b1; in_src = SRC_W'(src); in_addr = ADDR_W'(addr); in_data = DATA_W'(data);
        pg_rx_en = rx; pg_irq = irqf; pg_rx_err_ok = errok; req_ack = ack; in_err = bad;
        forever begin
            #(CLK_PERIOD/4);
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_err = 1'b0; req_ack = 1'b0;
    endtask

    task automatic clear(int src);
        @(negedge clk);
        clr_valid = 1'b1; clr_src = SRC_W'(src);
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        #(CLK_PERIOD/4);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 mem_valid", int'(mem_valid), 0);
        check("R1 ack_valid", int'(ack_valid), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_good_write();
        int w0 = wr_cnt;
        @(negedge clk);
        in_valid = 1'b1; in_src = 3'd1; in_addr = 16'h1234; in_data = 32'hCAFE0001;
        pg_rx_en = 1'b1; pg_irq = 1'b0; pg_rx_err_ok = 1'b0; req_ack = 1'b0; in_err = 1'b0;
        #(CLK_PERIOD/4);
        check("R2 mem_valid before accept", int'(mem_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        #(CLK_PERIOD/8);
        check("R2 mem_valid cycle after accept", int'(mem_valid), 1);
        settle();
        check("R2 write count", wr_cnt - w0, 1);
        check("R2 address", last_addr, 'h1234);
        check("R2 data", last_data, 'hCAFE0001);
    endtask

    task automatic t_rx_disabled();
        int w0 = wr_cnt;
        send(1, 'h55, 'h66, 0, 0, 0, 0, 0);
        settle();
        check("R3 no write when receive disabled", wr_cnt - w0, 0);
    endtask

    task automatic t_ack_good();
        int a0 = ack_cnt;
        send(3, 'h10, 'h20, 0, 0, 0, 1, 0);
        settle();
        check("R6 one ack", ack_cnt - a0, 1);
        check("R6 ack dst", last_dst, 3);
    endtask

    task automatic t_error_path();
        int w0 = wr_cnt, a0 = ack_cnt;
        send(2, 'h200, 'h1, 1, 0, 0, 1, 1);
        settle();
        check("R4 errored packet not written", wr_cnt - w0, 0);
        check("R4 errored packet not acked", ack_cnt - a0, 0);
        send(2, 'h201, 'h2, 1, 0, 0, 0, 0);
        settle();
        check("R5 later packet dropped", wr_cnt - w0, 0);
        send(3, 'h300, 'h3, 1, 0, 0, 0, 0);
        settle();
        check("R5 other path written", wr_cnt - w0, 1);
        check("R5 other path address", last_addr, 'h300);
    endtask

    task automatic t_err_ok_page();
        int w0 = wr_cnt, a0 = ack_cnt;
        send(2, 'h222, 'h77, 1, 0, 1, 1, 0);
        settle();
        check("R8 under-error page written", wr_cnt - w0, 1);
        check("R8 address", last_addr, 'h222);
        check("R7 no ack on errored path", ack_cnt - a0, 0);
    endtask

    task automatic t_collide();
        int w0;
        @(negedge clk);
        in_valid = 1'b1; in_src = 3'd6; in_err = 1'b1; pg_rx_en = 1'b1; pg_rx_err_ok = 1'b0;
        req_ack = 1'b0; pg_irq = 1'b0; clr_valid = 1'b1; clr_src = 3'd6;
        #(CLK_PERIOD/4);
        check("R10 in_ready at collision", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0; in_err = 1'b0; clr_valid = 1'b0;
        w0 = wr_cnt;
        send(6, 'h600, 'h6, 1, 0, 0, 0, 0);
        settle();
        check("R10 path stays in error", wr_cnt - w0, 0);
    endtask

    task automatic t_clear();
        int w0 = wr_cnt;
        clear(2);
        send(2, 'h2A0, 'h9, 1, 0, 0, 0, 0);
        settle();
        check("R9 cleared path written", wr_cnt - w0, 1);
        check("R9 address", last_addr, 'h2A0);
        send(6, 'h601, 'h9, 1, 0, 0, 0, 0);
        settle();
        check("R9 other errored path untouched", wr_cnt - w0, 1);
        clear(6);
    endtask

    task automatic t_irq();
        int i0 = irq_cnt;
        send(4, 'h400, 'h4, 1, 1, 0, 0, 0);
        settle();
        check("R11 one irq pulse", irq_cnt - i0, 1);
        i0 = irq_cnt;
        send(4, 'h401, 'h4, 1, 0, 0, 0, 0);
        send(4, 'h402, 'h4, 0, 1, 0, 0, 0);
        settle();
        check("R11 no irq without flag or write", irq_cnt - i0, 0);
    endtask

    task automatic t_ack_full();
        int a0 = ack_cnt;
        @(negedge clk);
        ack_ready = 1'b0;
        send(1, 0, 0, 0, 0, 0, 1, 0);
        send(5, 0, 0, 0, 0, 0, 1, 0);
        #(CLK_PERIOD/4);
        check("R12 stall when queue full", int'(in_ready), 0);
        check("R12 ack head", int'(ack_dst), 1);
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        check("R12 ack head held", int'(ack_dst), 1);
        @(negedge clk);
        ack_ready = 1'b1;
        settle();
        check("R12 two acks drained", ack_cnt - a0, 2);
        check("R12 last ack dst", last_dst, 5);
    endtask

    task automatic t_mem_stall();
        int w0 = wr_cnt;
        @(negedge clk);
        mem_ready = 1'b0;
        send(5, 'h555, 'hABCD, 1, 0, 0, 0, 0);
        #(CLK_PERIOD/4);
        check("R13 stall on pending write", int'(in_ready), 0);
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        check("R13 write held", int'(mem_valid), 1);
        check("R13 address held", int'(mem_addr), 'h555);
        @(negedge clk);
        mem_ready = 1'b1;
        settle();
        check("R13 write completed once", wr_cnt - w0, 1);
        check("R13 data", last_data, 'hABCD);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_good_write();
        t_rx_disabled();
        t_ack_good();
        t_error_path();
        t_err_ok_page();
        t_collide();
        t_clear();
        t_irq();
        t_ack_full();
        t_mem_stall();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule